// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a fixed-point signal processing engine. It has two 16-bit operand registers that hold two's-complement fractions in the range from -1 up to 1 - 2^-15. A fractional multiplier takes both registers and produces a product. The product is truncated to 24 bits and stored in a product register. A source multiplexer selects the second ALU operand: either the product register, or a 16-bit bus word placed on the upper bits of the 24-bit path. That operand goes through a four-way pre-shifter and then into an adder/subtractor. The other input of the adder/subtractor is the 24-bit accumulator.

A controller outside the block drives the write enables, the multiply enable, the source select, the shift code and the accumulator operation on every cycle. All state updates happen on the same rising edge. A product captured on one edge can be accumulated on the next edge. The accumulator never saturates: it wraps modulo 2^24.

Top module: `fmac_datapath`

## Requirements
- R1: While rst_ni is low, the X register, the Y register, the product register and the accumulator are all zero. prod_o and acc_o therefore read 0.
- R2: The X register loads x_data_i on a rising edge only when x_we_i is 1, and the Y register loads y_data_i only when y_we_i is 1. Otherwise each keeps its value, whatever is on its data input.
- R3: When mul_en_i is 1 at a rising edge, the product register takes bits [31:8] of (X*Y)<<1, where X and Y are signed 16-bit values. The discarded low bits are truncated, not rounded. When mul_en_i is 0 the product register holds its value.
- R4: When both X and Y hold 16'h8000, a multiply stores 24'h800000, which is -1, and never a positive value.
- R5: src_sel_i = 0 selects the product register as the ALU operand. src_sel_i = 1 selects {bus_data_i, 8'h00}, with the bus word on bits [23:8] and zeros on bits [7:0].
- R6: shift_i selects the pre-shift: 0 = no shift, 1 = arithmetic right by 1, 2 = arithmetic right by 3, 3 = left by 1. Right shifts copy the sign bit into the vacated bits. The left shift fills bit 0 with zero and drops bit 23.
- R7: acc_op_i selects the accumulator update: 0 = hold, 1 = load the shifted operand, 2 = accumulator plus shifted operand, 3 = accumulator minus shifted operand. Results wrap modulo 2^24.
- R8: Each load, multiply and accumulate takes effect on the first rising edge after its controls are applied. The result is visible on prod_o and acc_o right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_we_i | input | 1 | Write enable for the X operand register |
| x_data_i | input | 16 | Data for the X operand register |
| y_we_i | input | 1 | Write enable for the Y operand register |
| y_data_i | input | 16 | Data for the Y operand register |
| mul_en_i | input | 1 | Capture the truncated product into the product register |
| src_sel_i | input | 1 | ALU operand source: 0 = product register, 1 = bus word |
| bus_data_i | input | 16 | Bus word for the ALU operand path |
| shift_i | input | 2 | Pre-shift mode code |
| acc_op_i | input | 2 | Accumulator operation code |
| prod_o | output | 24 | Product register |
| acc_o | output | 24 | Accumulator |

## Verification
Assertions check on every cycle that the operand registers and the product register hold when they are not enabled, that the accumulator holds on code 0, that a load copies exactly the shifted operand, and that a multiply of two 16'h8000 operands lands on 24'h800000. The bench scenarios cover the rest, because they need an arithmetic reference: correct truncation of random and corner products, sign fill and wrap in each shift mode, placement of the bus word with zero fill, and add/subtract wrap across the 24-bit boundary.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_R1   = 2'd1,
    SH_R3   = 2'd2,
    SH_L1   = 2'd3
  } shift_mode_e;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_LOAD = 2'd1,
    ACC_ADD  = 2'd2,
    ACC_SUB  = 2'd3
  } acc_op_e;
endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
  parameter int OPW   = 16,
  parameter int PRODW = 24
) (
  input  logic [OPW-1:0]   a_i,
  input  logic [OPW-1:0]   b_i,
  output logic [PRODW-1:0] p_o
);
  localparam int FULLW = 2 * OPW;
  localparam logic [OPW-1:0]   MIN_OP  = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [PRODW-1:0] NEG_ONE = {1'b1, {(PRODW-1){1'b0}}};

  logic signed [FULLW-1:0] raw;
  logic        [FULLW-1:0] q_full;
  logic                    both_min;

  always_comb begin
    raw      = $signed(a_i) * $signed(b_i);
    q_full   = FULLW'(raw) << 1;  // Q(2n-2) to Q(2n-1)
    both_min = (a_i == MIN_OP) && (b_i == MIN_OP);
    p_o      = both_min ? NEG_ONE : q_full[FULLW-1 -: PRODW];
  end
endmodule

// File: rtl/fmac_shift.sv
module fmac_shift
  import fmac_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] d_i,
  input  shift_mode_e  mode_i,
  output logic [W-1:0] d_o
);
  always_comb begin
    unique case (mode_i)
      SH_R1:   d_o = {d_i[W-1], d_i[W-1:1]};
      SH_R3:   d_o = {{3{d_i[W-1]}}, d_i[W-1:3]};
      SH_L1:   d_o = {d_i[W-2:0], 1'b0};
      default: d_o = d_i;
    endcase
  end
endmodule

// File: rtl/fmac_alu.sv
module fmac_alu
  import fmac_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  acc_op_e      op_i,
  output logic [W-1:0] acc_nx_o
);
  always_comb begin
    unique case (op_i)
      ACC_LOAD: acc_nx_o = opd_i;
      ACC_ADD:  acc_nx_o = acc_i + opd_i;
      ACC_SUB:  acc_nx_o = acc_i - opd_i;
      default:  acc_nx_o = acc_i;
    endcase
  end
endmodule

// File: rtl/fmac_datapath.sv
module fmac_datapath
  import fmac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            x_we_i,
  input  logic [OPW-1:0]  x_data_i,
  input  logic            y_we_i,
  input  logic [OPW-1:0]  y_data_i,
  input  logic            mul_en_i,
  input  logic            src_sel_i,
  input  logic [OPW-1:0]  bus_data_i,
  input  logic [1:0]      shift_i,
  input  logic [1:0]      acc_op_i,
  output logic [ACCW-1:0] prod_o,
  output logic [ACCW-1:0] acc_o
);
  localparam int PAD = ACCW - OPW;
  localparam logic [OPW-1:0] MIN_OP = {1'b1, {(OPW-1){1'b0}}};

  logic [OPW-1:0]  x_q, y_q;
  logic [ACCW-1:0] prod_d, prod_q;
  logic [ACCW-1:0] bus_ext, opd_sel, opd_sh;
  logic [ACCW-1:0] acc_d, acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      if (x_we_i) x_q <= x_data_i;
      if (y_we_i) y_q <= y_data_i;
    end
  end

  fmac_mult #(.OPW(OPW), .PRODW(ACCW)) u_mult (
    .a_i (x_q),
    .b_i (y_q),
    .p_o (prod_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prod_q <= '0;
    else if (mul_en_i) prod_q <= prod_d;
  end

  generate
    if (PAD > 0) begin : g_pad
      assign bus_ext = {bus_data_i, {PAD{1'b0}}};
    end else begin : g_nopad
      assign bus_ext = bus_data_i[OPW-1 -: ACCW];
    end
  endgenerate

  assign opd_sel = src_sel_i ? bus_ext : prod_q;

  fmac_shift #(.W(ACCW)) u_shift (
    .d_i    (opd_sel),
    .mode_i (shift_mode_e'(shift_i)),
    .d_o    (opd_sh)
  );

  fmac_alu #(.W(ACCW)) u_alu (
    .acc_i    (acc_q),
    .opd_i    (opd_sh),
    .op_i     (acc_op_e'(acc_op_i)),
    .acc_nx_o (acc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign prod_o = prod_q;
  assign acc_o  = acc_q;

  // R2
  x_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_we_i |=> $stable(x_q));
  // R2
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_we_i |=> $stable(y_q));
  // R3
  prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mul_en_i |=> $stable(prod_q));
  // R4
  neg_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_en_i && x_q == MIN_OP && y_q == MIN_OP) |=> prod_q == {1'b1, {(ACCW-1){1'b0}}});
  // R7
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_op_i == ACC_HOLD |=> $stable(acc_q));
  // R7
  acc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_op_i == ACC_LOAD |=> acc_q == $past(opd_sh));
endmodule

// File: tb/fmac_datapath_bench.sv
module fmac_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x_we = 1'b0, y_we = 1'b0, mul_en = 1'b0, src_sel = 1'b0;
  logic [15:0] x_data = '0, y_data = '0, bus_data = '0;
  logic [1:0]  shift = '0, acc_op = '0;
  logic [23:0] prod, acc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [23:0] prod;
    logic [23:0] acc;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state
  logic [15:0] m_x = '0, m_y = '0;
  logic [23:0] m_p = '0, m_a = '0;

  always #5 clk = ~clk;

  fmac_datapath u_fmac_datapath (
    .clk_i(clk), .rst_ni(rst_n),
    .x_we_i(x_we), .x_data_i(x_data), .y_we_i(y_we), .y_data_i(y_data),
    .mul_en_i(mul_en), .src_sel_i(src_sel), .bus_data_i(bus_data),
    .shift_i(shift), .acc_op_i(acc_op), .prod_o(prod), .acc_o(acc)
  );

  function automatic logic [23:0] ref_frac(logic [15:0] a, logic [15:0] b);
    longint p;
    logic [63:0] t;
    if (a == 16'h8000 && b == 16'h8000) return 24'h800000;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    t = p;
    return t[31:8];
  endfunction

  function automatic logic [23:0] ref_shift(logic [23:0] d, logic [1:0] m);
    int v;
    logic [31:0] t;
    v = int'($signed(d));
    case (m)
      2'd1: v = (v - ((v % 2 + 2) % 2)) / 2;   // floor division
      2'd2: v = (v - ((v % 8 + 8) % 8)) / 8;
      2'd3: v = v * 2;
      default: ;
    endcase
    t = v;
    return t[23:0];
  endfunction

  function automatic void check(string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %06h expected %06h", tag, what, act, exp);
    end
  endfunction

  task automatic step(input bit xw, input logic [15:0] xd, input bit yw, input logic [15:0] yd,
                      input bit mu, input bit src, input logic [15:0] bd,
                      input logic [1:0] sh, input logic [1:0] op, input string tag);
    logic [23:0] opd, sh_v, np, na;
    exp_t e;
    @(negedge clk);
    x_we = xw; x_data = xd; y_we = yw; y_data = yd;
    mul_en = mu; src_sel = src; bus_data = bd; shift = sh; acc_op = op;
    np   = mu ? ref_frac(m_x, m_y) : m_p;
    opd  = src ? {bd, 8'h00} : m_p;
    sh_v = ref_shift(opd, sh);
    case (op)
      2'd1: na = sh_v;
      2'd2: na = m_a + sh_v;
      2'd3: na = m_a - sh_v;
      default: na = m_a;
    endcase
    if (xw) m_x = xd;
    if (yw) m_y = yd;
    m_p = np;
    m_a = na;
    e.prod = np; e.acc = na; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares one expected item after every edge that has one
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, "prod", prod, e.prod);
      check(e.tag, "acc", acc, e.acc);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] cv[3];
    cv[0] = 16'h8000; cv[1] = 16'h7FFF; cv[2] = 16'h0000;
    x_data = 16'hFFFF; x_we = 1'b1; mul_en = 1'b1; acc_op = 2'd1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "prod", prod, 24'h0);
    check("R1", "acc", acc, 24'h0);
    x_we = 1'b0; mul_en = 1'b0; acc_op = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;

    // R8 operand load then product next cycle: 0.5*0.5 = 0x200000
    step(1, 16'h4000, 1, 16'h4000, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R5");
    // R2 data changes without enable must not affect product
    step(0, 16'h1234, 0, 16'h8000, 1, 0, 0, 0, 0, "R2");
    step(1, 16'hC000, 0, 16'h7777, 1, 0, 0, 0, 2, "R2");
    step(0, 0, 0, 0, 1, 0, 0, 0, 2, "R3");
    // R4 minus one times minus one
    step(1, 16'h8000, 1, 16'h8000, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R4");
    // R3 corner products
    foreach (cv[i]) foreach (cv[j]) begin
      step(1, cv[i], 1, cv[j], 0, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 1, 0, 0, 0, 2, "R3");
    end
    // R3 truncation of a small negative product
    step(1, 16'hFFFF, 1, 16'h0001, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, 0, 0, 0, 1, "R3");
    // R5 and R6 bus word through each shift mode
    step(0, 0, 0, 0, 0, 1, 16'h8001, 0, 1, "R5");
    step(0, 0, 0, 0, 0, 1, 16'h8001, 1, 1, "R6");
    step(0, 0, 0, 0, 0, 1, 16'h8001, 2, 1, "R6");
    step(0, 0, 0, 0, 0, 1, 16'h8001, 3, 1, "R6");
    step(0, 0, 0, 0, 0, 1, 16'h4003, 3, 1, "R6");
    step(0, 0, 0, 0, 0, 1, 16'h0009, 2, 1, "R6");
    // R7 wrap on add and subtract, and hold
    step(0, 0, 0, 0, 0, 1, 16'h7FFF, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 1, 16'h7FFF, 0, 2, "R7");
    step(0, 0, 0, 0, 0, 1, 16'h5555, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 16'h8000, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 1, 16'h0001, 0, 3, "R7");
    // random mix
    for (int k = 0; k < 400; k++) begin
      step(1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom),
           1'($urandom), 16'($urandom), 2'($urandom), 2'($urandom), "R8");
    end
    @(negedge clk);
    acc_op = 2'd0; mul_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule